// File: doc/BRIEF.md
# Write-Back Data Cache Tag and Control Unit

This block keeps the tag, valid, dirty and recency state of an eight-way set-associative data cache serving the memory stage of a pipeline. There are 256 sets of 32-byte lines, for 64 KB in total. The pipeline presents a load or a store with its address. If the line is resident, `hit` rises in the same cycle and the access completes at the next clock edge. Load misses and store misses both allocate a line. The block raises `stall` for a fixed memory latency and installs the line in the last stall cycle. If the line it replaces is dirty, a writeback request for that line goes out in that same cycle, with no extra delay.

The requester keeps its request on the ports while `stall` is high. When `stall` drops, the held request finds the new line resident and completes as a hit. The controller is a three-state machine:
- `S_IDLE` looks up the request.
- `S_WAIT` counts out the memory latency.
- `S_FILL` installs the line and issues any writeback.

The transitions are:
- miss-detect: `S_IDLE` to `S_WAIT`, on a valid request that misses.
- latency-done: `S_WAIT` to `S_FILL`, when the wait count reaches its limit.
- fill-done: `S_FILL` to `S_IDLE`, always.

Top module: `dcache_ctrl`

## Requirements
- R1: The set index is address bits [12:5] and the tag is bits [31:13]. Eight lines with different tags in one set are all resident together.
- R2: When `req_valid` is high in the idle state and the line is resident, `hit` is 1 and `stall` is 0 in that same cycle.
- R3: On a miss, `stall` stays high for exactly 50 consecutive cycles, starting with the request cycle. In the first cycle after that, the held request reports `hit`=1.
- R4: A store miss allocates the line just as a load miss does, and the line it installs is dirty.
- R5: A fill uses the lowest-numbered invalid way if the set has one. Otherwise it replaces the least-recently-used way. The installed line becomes most-recently-used.
- R6: A hit makes the line most-recently-used.
- R7: A store hit marks its line dirty. A load leaves the dirty state unchanged.
- R8: When a fill evicts a valid dirty line, `wb_valid` is high for exactly one cycle, which is the 50th stall cycle. `wb_addr` then equals {victim tag, set index, 5'b0}. Evicting a clean line, or filling an invalid way, raises no `wb_valid`.
- R9: After reset, `stall` and `wb_valid` are 0 and no line is resident.
- R10: `hit` is never high while `stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A load or store is presented |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the access |
| stall | output | 1 | Miss in progress; hold the request |
| hit | output | 1 | Request hits and completes this cycle |
| wb_valid | output | 1 | Writeback request strobe for a dirty victim |
| wb_addr | output | 32 | Line address of the dirty victim |

## Verification
Corrupted recency ages show up as the wrong victim. The evidence is a later miss on a line that should still be resident, or a writeback address that names the wrong line, and it appears at the first miss into that set once the set is full. A lost or extra dirty bit shows up only when that line is evicted, as a missing or spurious `wb_valid`. The stimulus therefore keeps a few sets under heavy pressure so that evictions come quickly. An error in the latency counter shows up in the first miss as a stall that is not 50 cycles long.

// File: rtl/dc_pkg.sv
package dc_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_FILL = 2'd2
    } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
    parameter int SETS  = 256,
    parameter int WAYS  = 8,
    parameter int TAG_W = 19,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic [WAY_W-1:0] vic_way,
    input  logic             fill_en,
    input  logic             fill_dirty,
    input  logic             mark_en,
    input  logic [WAY_W-1:0] mark_way,
    output logic [WAYS-1:0]  hit_vec,
    output logic [WAYS-1:0]  valid_vec,
    output logic             vic_valid,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic             valid_q [SETS][WAYS];
    logic             dirty_q [SETS][WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign valid_vec[w] = valid_q[set_idx][w];
        assign hit_vec[w]   = valid_q[set_idx][w] && (tag_q[set_idx][w] == cmp_tag);
    end

    assign vic_valid = valid_q[set_idx][vic_way];
    assign vic_dirty = dirty_q[set_idx][vic_way];
    assign vic_tag   = tag_q[set_idx][vic_way];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]   <= '0;
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                end
            end
        end else if (fill_en) begin
            tag_q[set_idx][vic_way]   <= cmp_tag;
            valid_q[set_idx][vic_way] <= 1'b1;
            dirty_q[set_idx][vic_way] <= fill_dirty;
        end else if (mark_en) begin
            dirty_q[set_idx][mark_way] <= 1'b1;
        end
    end
endmodule

// File: rtl/dc_lru.sv
module dc_lru #(
    parameter int SETS = 256,
    parameter int WAYS = 8,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic [WAYS-1:0]  valid_vec,
    input  logic             touch_en,
    input  logic             touch_fill,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] vic_way
);
    localparam logic [WAY_W-1:0] AGE_MAX = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] old_age;

    always_comb begin
        vic_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (valid_vec[w] && age_q[set_idx][w] == AGE_MAX) vic_way = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) vic_way = WAY_W'(w);
        end
    end

    assign old_age = touch_fill ? AGE_MAX : age_q[set_idx][touch_way];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= '0;
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[set_idx][w] <= '0;
                else if (valid_vec[w] && age_q[set_idx][w] < old_age)
                    age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dc_fsm.sv
module dc_fsm
    import dc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MISS_LAT = 50,
    localparam int CNT_W   = $clog2(MISS_LAT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              any_hit,
    output dc_state_e         state,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              lat_we,
    output logic              stall,
    output logic              hit,
    output logic              fill_en,
    output logic              hit_en
);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(MISS_LAT - 3);

    dc_state_e        nxt;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (req_valid && !any_hit) nxt = S_WAIT;
            S_WAIT:  if (cnt_q == WAIT_LAST) nxt = S_FILL;
            S_FILL:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt_q    <= '0;
            lat_addr <= '0;
            lat_we   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE) begin
                cnt_q <= '0;
                if (req_valid && !any_hit) begin
                    lat_addr <= req_addr;
                    lat_we   <= req_we;
                end
            end else if (state == S_WAIT) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        stall   = 1'b0;
        hit     = 1'b0;
        fill_en = 1'b0;
        hit_en  = 1'b0;
        unique case (state)
            S_IDLE: begin
                hit    = req_valid && any_hit;
                hit_en = req_valid && any_hit;
                stall  = req_valid && !any_hit;
            end
            S_WAIT:  stall = 1'b1;
            S_FILL: begin
                stall   = 1'b1;
                fill_en = 1'b1;
            end
            default: stall = 1'b0;
        endcase
    end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
    import dc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WAYS       = 8,
    parameter int SETS       = 256,
    parameter int LINE_BYTES = 32,
    parameter int MISS_LAT   = 50,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              stall,
    output logic              hit,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr
);
    dc_state_e         state;
    logic [ADDR_W-1:0] lat_addr, look_addr;
    logic              lat_we, fill_en, hit_en, any_hit;
    logic [WAYS-1:0]   hit_vec, valid_vec;
    logic [WAY_W-1:0]  hit_way, vic_way;
    logic              vic_valid, vic_dirty;
    logic [TAG_W-1:0]  vic_tag;
    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  tag_in;

    assign look_addr = (state == S_IDLE) ? req_addr : lat_addr;
    assign set_idx   = look_addr[OFF_W +: SET_W];
    assign tag_in    = look_addr[ADDR_W-1 -: TAG_W];
    assign any_hit   = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    dc_fsm #(.ADDR_W(ADDR_W), .MISS_LAT(MISS_LAT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .any_hit(any_hit), .state(state),
        .lat_addr(lat_addr), .lat_we(lat_we), .stall(stall), .hit(hit),
        .fill_en(fill_en), .hit_en(hit_en)
    );

    dc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .cmp_tag(tag_in),
        .vic_way(vic_way), .fill_en(fill_en), .fill_dirty(lat_we),
        .mark_en(hit_en && req_we), .mark_way(hit_way),
        .hit_vec(hit_vec), .valid_vec(valid_vec), .vic_valid(vic_valid),
        .vic_dirty(vic_dirty), .vic_tag(vic_tag)
    );

    dc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .valid_vec(valid_vec),
        .touch_en(hit_en || fill_en), .touch_fill(fill_en),
        .touch_way(fill_en ? vic_way : hit_way), .vic_way(vic_way)
    );

    assign wb_valid = fill_en && vic_valid && vic_dirty;
    assign wb_addr  = {vic_tag, set_idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/dc_chk.sv
module dc_chk #(
    parameter int MISS_LAT = 50
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic stall,
    input logic hit,
    input logic wb_valid
);
    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= stall ? run_q + 16'd1 : 16'd0;
    end

    // R3
    stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (run_q == 16'(MISS_LAT)));

    // R3
    retry_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stall) && req_valid) |-> hit);

    // R8
    wb_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (stall && run_q == 16'(MISS_LAT - 1)));

    // R8
    wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    // R10
    hit_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !stall);
endmodule

bind dcache_ctrl dc_chk #(.MISS_LAT(MISS_LAT)) u_dc_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .stall(stall),
    .hit(hit), .wb_valid(wb_valid)
);

// File: tb/tb_dcache_ctrl.sv
module tb_dcache_ctrl;
    localparam int SETS = 256;
    localparam int WAYS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic        stall, hit, wb_valid;
    logic [31:0] wb_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [18:0] m_tag   [SETS][WAYS];
    bit          m_valid [SETS][WAYS];
    bit          m_dirty [SETS][WAYS];
    int          m_stamp [SETS][WAYS];
    int          now = 0;

    dcache_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .stall(stall), .hit(hit), .wb_valid(wb_valid),
        .wb_addr(wb_addr)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int m_find(input logic [31:0] a);
        for (int w = 0; w < WAYS; w++)
            if (m_valid[a[12:5]][w] && m_tag[a[12:5]][w] == a[31:13]) return w;
        return -1;
    endfunction

    function automatic int m_victim(input logic [7:0] s);
        int best = 0;
        for (int w = 0; w < WAYS; w++) if (!m_valid[s][w]) return w;
        for (int w = 1; w < WAYS; w++) if (m_stamp[s][w] < m_stamp[s][best]) best = w;
        return best;
    endfunction

    function automatic logic [31:0] mk(input int tag, input int set, input int off);
        return {19'(tag), 8'(set), 5'(off)};
    endfunction

    task automatic acc(input bit we, input logic [31:0] a, output bit was_hit);
        int          w, v, n, wb_at;
        logic [31:0] wb_seen, wb_exp;
        bit          exp_wb;
        logic [7:0]  s;
        s = a[12:5];
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a;
        #2;
        w = m_find(a);
        was_hit = hit;
        // R2 R10
        check(hit == (w >= 0), "R2", 32'(hit), 32'(w >= 0));
        check(stall == (w < 0), "R10", 32'(stall), 32'(w < 0));
        if (w < 0) begin
            v = m_victim(s);
            exp_wb = m_valid[s][v] && m_dirty[s][v];
            wb_exp = {m_tag[s][v], s, 5'b0};
            n = 0; wb_at = 0; wb_seen = '0;
            while (stall && n < 200) begin
                if (wb_valid) begin
                    wb_at = (wb_at == 0) ? n + 1 : -1;
                    wb_seen = wb_addr;
                end
                n++;
                @(negedge clk); #2;
            end
            // R3
            check(n == 50, "R3 stall length", 32'(n), 32'd50);
            check(hit == 1'b1, "R3 retry hit", 32'(hit), 32'd1);
            // R8
            check(wb_at == (exp_wb ? 50 : 0), "R8 wb timing", 32'(wb_at), exp_wb ? 32'd50 : 32'd0);
            if (exp_wb) check(wb_seen == wb_exp, "R8 wb addr", wb_seen, wb_exp);
            m_tag[s][v] = a[31:13];
            m_valid[s][v] = 1'b1;
            m_dirty[s][v] = we;
            w = v;
        end
        if (we) m_dirty[s][w] = 1'b1;
        now++;
        m_stamp[s][w] = now;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        bit h;
        void'($urandom(32'd4471));
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_dirty[s][w] = 0; m_stamp[s][w] = 0; m_tag[s][w] = '0;
            end
        #1;
        // R9 reset state
        check(stall == 1'b0, "R9 stall", 32'(stall), 32'd0);
        check(wb_valid == 1'b0, "R9 wb_valid", 32'(wb_valid), 32'd0);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R9: empty cache, first access misses
        acc(1'b0, mk(0, 5, 4), h);
        check(h == 1'b0, "R9 empty", 32'(h), 32'd0);
        // R2 hit, R7 store hit dirties
        acc(1'b0, mk(0, 5, 8), h);
        check(h == 1'b1, "R2 hit", 32'(h), 32'd1);
        acc(1'b1, mk(0, 5, 0), h);
        // R1: eight tags in set 5 coexist
        for (int t = 1; t < 8; t++) acc(1'b0, mk(t, 5, 0), h);
        for (int t = 0; t < 8; t++) begin
            acc(1'b0, mk(t, 5, 12), h);
            check(h == 1'b1, "R1 resident", 32'(h), 32'd1);
        end
        // R6: touch tags 0 and 1, then R5 evicts tag 2 (oldest)
        acc(1'b0, mk(0, 5, 0), h);
        acc(1'b0, mk(1, 5, 0), h);
        for (int t = 3; t < 8; t++) acc(1'b0, mk(t, 5, 0), h);
        acc(1'b0, mk(8, 5, 0), h);
        acc(1'b0, mk(0, 5, 0), h);
        check(h == 1'b1, "R6 touched line kept", 32'(h), 32'd1);
        acc(1'b0, mk(2, 5, 0), h);
        check(h == 1'b0, "R5 LRU evicted", 32'(h), 32'd0);
        // R1: same set bits, different tag bit 13 maps elsewhere in tag
        acc(1'b0, 32'h0000_2000 | mk(0, 9, 0), h);
        acc(1'b0, mk(0, 9, 0), h);
        check(h == 1'b0, "R1 tag bit 13", 32'(h), 32'd0);
        // R4: store miss allocates dirty; force eviction to see wb (R8)
        acc(1'b1, mk(20, 6, 3), h);
        acc(1'b0, mk(20, 6, 0), h);
        check(h == 1'b1, "R4 store allocates", 32'(h), 32'd1);
        for (int t = 21; t < 29; t++) acc(1'b0, mk(t, 6, 0), h);
        acc(1'b0, mk(20, 6, 0), h);
        check(h == 1'b0, "R4 dirty line evicted", 32'(h), 32'd0);
        // random mix over a small pool, compared with the model
        for (int i = 0; i < 400; i++) begin
            int sel = $urandom_range(0, 2);
            int set = (sel == 0) ? 3 : (sel == 1) ? 77 : 255;
            acc(1'($urandom_range(0, 1)), mk($urandom_range(0, 11), set, $urandom_range(0, 31)), h);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule